// File: doc/BRIEF.md
# Configurable NaN Result Selector

This block sits next to a single-precision floating-point datapath and works out what the NaN outcome of an operation should be. It accepts three 32-bit operands and a kind bit. The kind bit chooses between a two-operand operation that uses a and b, and a fused multiply-add a*b+c. The block sorts each operand into signaling NaN, quiet NaN, infinity or zero. It then reports whether the operation yields a NaN, which 32-bit NaN word to return, and whether invalid-operation must be raised. It does no arithmetic on ordinary numbers, does no rounding and does not flush denormals.

A single mode bit changes four things at once. It sets which state of the top fraction bit marks a NaN as quiet. It picks which default NaN word is used. It decides whether operand NaNs are passed through or always replaced by the default. It sets the search order used by the fused operation. Results are registered and become visible one clock after the input strobe.

Top module: `fpnan_prop_unit`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears o_valid, o_nan and o_invalid, and sets o_result to 0 on that edge. This holds even when i_valid is high in the same cycle.
- R2: o_valid at a rising edge equals i_valid at the edge before it. When i_valid was low, o_nan and o_invalid are 0 and o_result is 0.
- R3: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are not zero. With i_mode2008=1 the NaN is quiet when bit 22 is 1 and signaling when it is 0. With i_mode2008=0 this sense is inverted.
- R4: In a two-operand operation (i_fused=0) with i_mode2008=1, the result is chosen in this order: a if signaling, then b if signaling, then a if quiet, then b if quiet.
- R5: With i_mode2008=1, a signaling NaN that is chosen as the result comes back with bit 22 set. Its sign and its other fraction bits are kept.
- R6: With i_mode2008=0, every NaN result is 32'h7FBFFFFF. With i_mode2008=1, a NaN result that has no operand NaN to pass through is 32'h7FC00000.
- R7: In a fused operation with i_mode2008=1, signaling NaNs are searched in the order c, a, b, and quiet NaNs are then searched in the order c, a, b.
- R8: In a fused operation where one of a and b is an infinity, the other is a zero of either sign, and c is a NaN, o_invalid is raised. The result is c (quieted) when i_mode2008=1 and the default NaN when i_mode2008=0.
- R9: o_invalid is raised when any operand that is considered is a signaling NaN, or when the infinity-times-zero case occurs in a fused operation. If that case occurs with a non-NaN c, the result is the default NaN.
- R10: When no considered operand is a NaN and the infinity-times-zero fused case does not occur, o_nan=0, o_invalid=0 and o_result=0. A binary operation of infinity and zero is in this class.
- R11: When i_fused=0, operand c has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| i_valid | input | 1 | Operands present this cycle |
| i_fused | input | 1 | 1 = fused a*b+c, 0 = two-operand operation on a and b |
| i_mode2008 | input | 1 | 1 = newer NaN encoding and propagation, 0 = legacy |
| i_op_a | input | 32 | Operand a |
| i_op_b | input | 32 | Operand b |
| i_op_c | input | 32 | Operand c (addend; used only when fused) |
| o_valid | output | 1 | Registered copy of i_valid |
| o_nan | output | 1 | The operation's result is a NaN |
| o_result | output | 32 | NaN word to return, 0 when o_nan is low |
| o_invalid | output | 1 | Invalid-operation must be raised |

## Verification
Each result lands exactly one rising edge after its strobe, because a single register stage lies between the inputs and every output. The bench changes inputs on the falling edge and reads the outputs on the next falling edge. This means each table vector is checked half a cycle after the edge that captured it, while the next vector is already being applied back to back. The reset checks follow the same one-edge rule: rst_n is driven low on a falling edge, and the cleared outputs are read on the next falling edge.

// File: rtl/fpnan_pkg.sv
// Shared types and the operand search order for the NaN result selector.
// Assumes three operand slots: index 0 = a, 1 = b, 2 = c.
package fpnan_pkg;

    localparam int unsigned NOPS = 3;

    // Per-operand classification flags; at most one is set for any operand.
    typedef struct packed {
        logic snan;
        logic qnan;
        logic inf;
        logic zero;
    } opclass_t;

    // Operand index searched at rank k (0..2) for the given operation kind and mode.
    function automatic logic [1:0] search_slot(input logic fused, input logic m2008,
                                               input int unsigned k);
        logic [1:0] idx;
        if (fused && m2008) begin
            case (k)
                0:       idx = 2'd2;
                1:       idx = 2'd0;
                default: idx = 2'd1;
            endcase
        end else begin
            idx = 2'(k);
        end
        return idx;
    endfunction

endpackage

// File: rtl/fpnan_classify.sv
// Sorts one binary floating-point operand into signaling NaN, quiet NaN,
// infinity or zero under the selected encoding.
// Assumes layout {sign, exponent[EXP_W], fraction[FRAC_W]}.
module fpnan_classify
    import fpnan_pkg::*;
#(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op,
    input  logic                  mode2008,
    output opclass_t              cls
);

    localparam int unsigned W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              exp_min;
    logic              frac_nz;
    logic              is_nan;
    logic              sig_sense;

    // Split the operand into its fields.
    always_comb begin
        exp_f  = op[W-2 -: EXP_W];
        frac_f = op[FRAC_W-1:0];
    end

    // Derive the class flags; the top fraction bit's meaning follows the mode.
    always_comb begin
        exp_max   = &exp_f;
        exp_min   = ~|exp_f;
        frac_nz   = |frac_f;
        is_nan    = exp_max && frac_nz;
        sig_sense = frac_f[FRAC_W-1] ^ mode2008;
        cls.snan  = is_nan && sig_sense;
        cls.qnan  = is_nan && !sig_sense;
        cls.inf   = exp_max && !frac_nz;
        cls.zero  = exp_min && !frac_nz;
    end

    // R3
    always_comb begin
        class_excl_chk: assert ($onehot0({cls.snan, cls.qnan, cls.inf, cls.zero}));
    end

endmodule

// File: rtl/fpnan_select.sv
// Chooses the NaN result and invalid flag from the operand classes.
// Assumes classes come from fpnan_classify under the same mode bit.
// Pure combinational; the top registers the outputs.
module fpnan_select
    import fpnan_pkg::*;
#(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] ops [NOPS],
    input  opclass_t              cls [NOPS],
    input  logic                  fused,
    input  logic                  mode2008,
    output logic                  nan_out,
    output logic                  invalid_out,
    output logic [EXP_W+FRAC_W:0] res_out
);

    localparam int unsigned W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] DNAN_NEW = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] DNAN_LEG = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

    logic [NOPS-1:0] live;
    logic            any_nan;
    logic            any_snan;
    logic            izn;
    logic            izn_c;
    logic            found;
    logic [1:0]      pick;
    logic            unused_cls;

    assign unused_cls = ^{cls[2].inf, cls[2].zero};

    // Mark which operands take part, then gather the NaN and inf*0 conditions.
    always_comb begin
        any_nan  = 1'b0;
        any_snan = 1'b0;
        for (int i = 0; i < NOPS; i++) begin
            live[i]  = (i < 2) || fused;
            any_nan  = any_nan  || (live[i] && (cls[i].snan || cls[i].qnan));
            any_snan = any_snan || (live[i] && cls[i].snan);
        end
        izn   = fused && ((cls[0].inf && cls[1].zero) || (cls[0].zero && cls[1].inf));
        izn_c = izn && (cls[2].snan || cls[2].qnan);
    end

    // Two passes of the ranked search: signaling NaNs first, then quiet ones.
    always_comb begin
        logic [1:0] idx;
        logic       cand;
        found = 1'b0;
        pick  = 2'd0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < NOPS; k++) begin
                idx  = search_slot(fused, mode2008, k);
                cand = live[idx] && ((pass == 0) ? cls[idx].snan : cls[idx].qnan);
                if (!found && cand) begin
                    found = 1'b1;
                    pick  = idx;
                end
            end
        end
        if (izn_c) begin
            found = 1'b1;
            pick  = 2'd2;
        end
    end

    // Form the flags and the result word, quieting the picked operand.
    always_comb begin
        nan_out     = any_nan || izn;
        invalid_out = any_snan || izn;
        if (!nan_out) begin
            res_out = '0;
        end else if (!mode2008) begin
            res_out = DNAN_LEG;
        end else if (!found) begin
            res_out = DNAN_NEW;
        end else begin
            res_out = ops[pick] | (W'(1) << (FRAC_W - 1));
        end
    end

    // R5
    always_comb begin
        new_quiet_chk: assert (!(mode2008 && nan_out) || res_out[FRAC_W-1]);
    end

    // R6
    always_comb begin
        leg_default_chk: assert (!(!mode2008 && nan_out) || res_out == DNAN_LEG);
    end

endmodule

// File: rtl/fpnan_prop_unit.sv
// Top of the NaN result selector: classifies the three operands, selects the
// NaN outcome and registers it one cycle after the input strobe.
// Assumes single-precision operands; rst_n is synchronous and active low.
module fpnan_prop_unit
    import fpnan_pkg::*;
#(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  i_valid,
    input  logic                  i_fused,
    input  logic                  i_mode2008,
    input  logic [EXP_W+FRAC_W:0] i_op_a,
    input  logic [EXP_W+FRAC_W:0] i_op_b,
    input  logic [EXP_W+FRAC_W:0] i_op_c,
    output logic                  o_valid,
    output logic                  o_nan,
    output logic [EXP_W+FRAC_W:0] o_result,
    output logic                  o_invalid
);

    localparam int unsigned W = 1 + EXP_W + FRAC_W;

    logic [W-1:0] ops [NOPS];
    opclass_t     cls [NOPS];
    logic         sel_nan;
    logic         sel_inv;
    logic [W-1:0] sel_res;

    // Gather the operands into indexed slots.
    always_comb begin
        ops[0] = i_op_a;
        ops[1] = i_op_b;
        ops[2] = i_op_c;
    end

    // One classifier per operand slot.
    for (genvar g = 0; g < NOPS; g++) begin : g_cls
        fpnan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) cls_i (
            .op       (ops[g]),
            .mode2008 (i_mode2008),
            .cls      (cls[g])
        );
    end

    fpnan_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) sel_i (
        .ops         (ops),
        .cls         (cls),
        .fused       (i_fused),
        .mode2008    (i_mode2008),
        .nan_out     (sel_nan),
        .invalid_out (sel_inv),
        .res_out     (sel_res)
    );

    // Output register; idle cycles and reset leave flags and result at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid   <= 1'b0;
            o_nan     <= 1'b0;
            o_invalid <= 1'b0;
            o_result  <= '0;
        end else begin
            o_valid   <= i_valid;
            o_nan     <= i_valid && sel_nan;
            o_invalid <= i_valid && sel_inv;
            o_result  <= i_valid ? sel_res : '0;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!o_valid && !o_nan && !o_invalid && o_result == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid |=> o_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !i_valid |=> (!o_valid && !o_nan && !o_invalid));

    // R9
    snan_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && (cls[0].snan || cls[1].snan || (i_fused && cls[2].snan))) |=> o_invalid);

    // R8
    izn_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && i_fused && ((cls[0].inf && cls[1].zero) || (cls[0].zero && cls[1].inf))
         && (cls[2].snan || cls[2].qnan)) |=> (o_invalid && o_nan));

endmodule

// File: tb/fpnan_prop_unit_tb.sv
// Self-checking bench for fpnan_prop_unit: a vector table walked back to back,
// then directed reset and idle tests.
module fpnan_prop_unit_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 19;

    // {fused, mode2008, a, b, c, exp_nan, exp_inv, exp_result}
    localparam logic [131:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 32'h7FC00011, 32'h7F800022, 32'h00000000, 1'b1, 1'b1, 32'h7FC00022},
        {1'b0, 1'b1, 32'h7F800033, 32'h7F800044, 32'h00000000, 1'b1, 1'b1, 32'h7FC00033},
        {1'b0, 1'b1, 32'h7FC00011, 32'hFFC00055, 32'h00000000, 1'b1, 1'b0, 32'h7FC00011},
        {1'b0, 1'b1, 32'h3F800000, 32'hFFC00055, 32'h00000000, 1'b1, 1'b0, 32'hFFC00055},
        {1'b0, 1'b1, 32'h3F800000, 32'h40000000, 32'h00000000, 1'b0, 1'b0, 32'h00000000},
        {1'b0, 1'b1, 32'h3F800000, 32'h40000000, 32'h7F800001, 1'b0, 1'b0, 32'h00000000},
        {1'b1, 1'b1, 32'h7F800033, 32'h3F800000, 32'h7FC00066, 1'b1, 1'b1, 32'h7FC00033},
        {1'b1, 1'b1, 32'h7FC00011, 32'h7F800044, 32'h7FC00066, 1'b1, 1'b1, 32'h7FC00044},
        {1'b1, 1'b1, 32'h7FC00011, 32'hFFC00055, 32'h7FC00066, 1'b1, 1'b0, 32'h7FC00066},
        {1'b1, 1'b1, 32'h7F800000, 32'h00000000, 32'h7FC00066, 1'b1, 1'b1, 32'h7FC00066},
        {1'b1, 1'b1, 32'h80000000, 32'hFF800000, 32'h7F800077, 1'b1, 1'b1, 32'h7FC00077},
        {1'b1, 1'b1, 32'h7F800000, 32'h00000000, 32'h3F800000, 1'b1, 1'b1, 32'h7FC00000},
        {1'b1, 1'b1, 32'h3F800000, 32'h40000000, 32'h40400000, 1'b0, 1'b0, 32'h00000000},
        {1'b0, 1'b0, 32'h7FC00001, 32'h3F800000, 32'h00000000, 1'b1, 1'b1, 32'h7FBFFFFF},
        {1'b0, 1'b0, 32'h7F800001, 32'h3F800000, 32'h00000000, 1'b1, 1'b0, 32'h7FBFFFFF},
        {1'b1, 1'b0, 32'h7F800000, 32'h00000000, 32'h7F800001, 1'b1, 1'b1, 32'h7FBFFFFF},
        {1'b1, 1'b0, 32'h7F800000, 32'h00000000, 32'h3F800000, 1'b1, 1'b1, 32'h7FBFFFFF},
        {1'b1, 1'b0, 32'h3F800000, 32'h3F800000, 32'h7F800005, 1'b1, 1'b0, 32'h7FBFFFFF},
        {1'b0, 1'b0, 32'h7F800000, 32'h00000000, 32'h7FC00001, 1'b0, 1'b0, 32'h00000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_valid = 1'b0;
    logic        i_fused = 1'b0;
    logic        i_mode2008 = 1'b0;
    logic [31:0] i_op_a = '0;
    logic [31:0] i_op_b = '0;
    logic [31:0] i_op_c = '0;
    logic        o_valid;
    logic        o_nan;
    logic [31:0] o_result;
    logic        o_invalid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpnan_prop_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .i_valid    (i_valid),
        .i_fused    (i_fused),
        .i_mode2008 (i_mode2008),
        .i_op_a     (i_op_a),
        .i_op_b     (i_op_b),
        .i_op_c     (i_op_c),
        .o_valid    (o_valid),
        .o_nan      (o_nan),
        .o_result   (o_result),
        .o_invalid  (o_invalid)
    );

    // Requirement tags exercised by each table row.
    function automatic string tag_of(input int i);
        case (i)
            0, 1:    return "R4 R5";
            2, 3:    return "R4";
            4:       return "R10";
            5:       return "R11";
            6, 7, 8: return "R7";
            9, 10:   return "R8";
            11:      return "R9";
            12:      return "R10";
            13, 14:  return "R3 R6";
            15:      return "R8";
            16:      return "R9";
            17:      return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input int i);
        i_valid    = 1'b1;
        i_fused    = VEC[i][131];
        i_mode2008 = VEC[i][130];
        i_op_a     = VEC[i][129:98];
        i_op_b     = VEC[i][97:66];
        i_op_c     = VEC[i][65:34];
    endtask

    task automatic check_vec(input int i);
        string t;
        t = $sformatf("%s vec%0d", tag_of(i), i);
        chk(t, "valid",   32'(o_valid),   32'd1);
        chk(t, "nan",     32'(o_nan),     32'(VEC[i][33]));
        chk(t, "invalid", 32'(o_invalid), 32'(VEC[i][32]));
        chk(t, "result",  o_result,       VEC[i][31:0]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "valid",   32'(o_valid),   32'd0);
        chk("R1", "nan",     32'(o_nan),     32'd0);
        chk("R1", "invalid", 32'(o_invalid), 32'd0);
        chk("R1", "result",  o_result,       32'd0);
        rst_n = 1'b1;

        // Table walked back to back; each row is read one edge after it is applied.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            if (i > 0) check_vec(i - 1);
            apply(i);
        end
        @(negedge clk);
        check_vec(NVEC - 1);

        // R2: an idle cycle with NaN inputs leaves the outputs quiet.
        i_valid    = 1'b0;
        i_fused    = 1'b1;
        i_mode2008 = 1'b1;
        i_op_a     = 32'h7F800001;
        i_op_b     = 32'h7F800002;
        i_op_c     = 32'h7F800003;
        @(negedge clk);
        chk("R2", "idle valid",   32'(o_valid),   32'd0);
        chk("R2", "idle nan",     32'(o_nan),     32'd0);
        chk("R2", "idle invalid", 32'(o_invalid), 32'd0);
        chk("R2", "idle result",  o_result,       32'd0);

        // R11: binary op with a signaling c next to quiet a and b still returns a.
        i_valid = 1'b1;
        i_fused = 1'b0;
        i_op_a  = 32'h7FC00123;
        i_op_b  = 32'h7FC00456;
        i_op_c  = 32'h7F800001;
        @(negedge clk);
        chk("R11", "invalid", 32'(o_invalid), 32'd0);
        chk("R11", "result",  o_result,       32'h7FC00123);

        // R1: reset wins over a valid NaN stimulus in the same cycle.
        i_op_a = 32'h7F800009;
        rst_n  = 1'b0;
        @(negedge clk);
        chk("R1", "mid valid",   32'(o_valid),   32'd0);
        chk("R1", "mid nan",     32'(o_nan),     32'd0);
        chk("R1", "mid invalid", 32'(o_invalid), 32'd0);
        chk("R1", "mid result",  o_result,       32'd0);
        rst_n   = 1'b1;
        i_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule